// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the interrupt state of a multi-channel DMA engine into one level-high interrupt line. Every channel owns a small bank of status bits, set by single-cycle event pulses from the channel logic, together with a matching enable register and a write-one-to-clear register. A controller-wide bank does the same for four engine-level events: timer, empty, error and bus error response.

The gathering happens in two levels. A read-only source word carries one summary bit per channel in bits 0 to 30 and one controller summary in bit 31. Each summary bit is the OR of its bank's status ANDed with its enables. A mask word of the same layout then decides which summaries may drive the output. Software reads the source word, visits the flagged banks, and clears them by writing back the bits it has handled.

Register access uses a simple word-addressed port: a write strobe with address and data, and a read data bus that follows the address combinationally.

Top module: `irq_aggr_top`

## Requirements
- R1: After reset every status, enable and mask bit is zero and `irq_o` is low.
- R2: A one on bit b of channel c's slice of `ch_evt_i` (bits c*CH_EVT_W+b) sets status bit b of channel c on the next clock edge, whether or not it is enabled. A write to the channel clear register (address 0x10+4c+1) clears exactly the status bits written as one. Without an event or a clear, the status holds.
- R3: When an event and a clear of the same status bit fall in the same cycle, the bit is set afterwards. This holds for channel and controller banks alike.
- R4: Source bit c (address 0x03, read-only) is one exactly when channel c has a status bit that is set and enabled. Bits for channels at or above NUM_CH read zero.
- R5: Controller status (address 0x00) keeps timer in bit 4, empty in bit 3, error in bit 2 and bus error response in bit 1, fed from `ctl_evt_i` at the same positions. Bit 0 and bits 31:5 always read zero. The controller clear register (0x01) is write-one-to-clear, and the controller enable register (0x02) uses the same bit positions.
- R6: Source bit 31 is one exactly when a controller status bit is set and enabled.
- R7: `irq_o` is high exactly when a source bit and its mask bit (address 0x04, read/write, all 32 bits) are both one. It stays high until that condition ends.
- R8: Writes to the source register have no effect on any state.
- R9: Channel c's registers sit at 0x10+4c: +0 status, +1 clear, +2 enable. Enable registers read back only their implemented bits. Clear registers read zero. Addresses that map to no register, including channels at or above NUM_CH, read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Word address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the addressed register |
| ch_evt_i | input | NUM_CH*CH_EVT_W | Per-channel event pulses, channel c in bits c*CH_EVT_W and up |
| ctl_evt_i | input | 5 | Controller event pulses, bits 4:1 used, bit 0 ignored |
| irq_o | output | 1 | Level-high aggregated interrupt |

## Verification
The bench builds the block with NUM_CH=5 and CH_EVT_W=6. With five channels, source bits 5 to 30 and the channel address windows from 0x24 upward belong to channels that are absent, so both the zero read-back and the ignored writes for unimplemented channels can be reached. Six-bit channel banks let a full-word enable write show that only the implemented bits are stored.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int CTL_W     = 5;
    localparam int CH_IDX_W  = 5;
    localparam int MAX_CH    = 31;

    // controller event positions
    localparam int CTL_BIT_BUSERR = 1;
    localparam int CTL_BIT_ERROR  = 2;
    localparam int CTL_BIT_EMPTY  = 3;
    localparam int CTL_BIT_TIMER  = 4;
    localparam logic [CTL_W-1:0] CTL_VALID = 5'b11110;

    localparam logic [ADDR_W-1:0] ADR_CTL_STAT = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_CTL_CLR  = 8'h01;
    localparam logic [ADDR_W-1:0] ADR_CTL_EN   = 8'h02;
    localparam logic [ADDR_W-1:0] ADR_SRC      = 8'h03;
    localparam logic [ADDR_W-1:0] ADR_MASK     = 8'h04;
    localparam logic [ADDR_W-1:0] ADR_CH_BASE  = 8'h10;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTL_STAT,
        SEL_CTL_CLR,
        SEL_CTL_EN,
        SEL_SRC,
        SEL_MASK,
        SEL_CH_STAT,
        SEL_CH_CLR,
        SEL_CH_EN
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e              sel;
        logic [CH_IDX_W-1:0]   ch;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a, input int num_ch);
        reg_dec_t          d;
        logic [ADDR_W-1:0] off;
        d.sel = SEL_NONE;
        d.ch  = '0;
        off   = a - ADR_CH_BASE;
        case (a)
            ADR_CTL_STAT: d.sel = SEL_CTL_STAT;
            ADR_CTL_CLR:  d.sel = SEL_CTL_CLR;
            ADR_CTL_EN:   d.sel = SEL_CTL_EN;
            ADR_SRC:      d.sel = SEL_SRC;
            ADR_MASK:     d.sel = SEL_MASK;
            default: begin
                if (a >= ADR_CH_BASE && int'(off[ADDR_W-1:2]) < num_ch) begin
                    d.ch = off[2 +: CH_IDX_W];
                    case (off[1:0])
                        2'd0:    d.sel = SEL_CH_STAT;
                        2'd1:    d.sel = SEL_CH_CLR;
                        2'd2:    d.sel = SEL_CH_EN;
                        default: d.sel = SEL_NONE;
                    endcase
                end
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
    parameter int             W     = 6,
    parameter logic [W-1:0]   VALID = '1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] evt_i,
    input  logic         clr_we_i,
    input  logic         en_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] en_o,
    output logic         pend_o
);
    logic [W-1:0] stat_q, en_q, clr_bits, stat_d;

    assign clr_bits = clr_we_i ? wdata_i : '0;
    // a fresh event overrides a clear of the same bit
    assign stat_d   = ((stat_q & ~clr_bits) | evt_i) & VALID;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= stat_d;
            if (en_we_i) en_q <= wdata_i & VALID;
        end
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign pend_o = |(stat_q & en_q);
endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate
    import irq_aggr_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] ch_pend_i,
    input  logic              ctl_pend_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] src_o,
    output logic              irq_o
);
    always_comb begin
        src_o                 = '0;
        src_o[NUM_CH-1:0]     = ch_pend_i;
        src_o[DATA_W-1]       = ctl_pend_i;
    end

    assign irq_o = |(src_o & mask_i);
endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
    import irq_aggr_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int CH_EVT_W = 6
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       reg_we_i,
    input  logic [ADDR_W-1:0]          reg_addr_i,
    input  logic [DATA_W-1:0]          reg_wdata_i,
    output logic [DATA_W-1:0]          reg_rdata_o,
    input  logic [NUM_CH*CH_EVT_W-1:0] ch_evt_i,
    input  logic [CTL_W-1:0]           ctl_evt_i,
    output logic                       irq_o
);
    localparam int CH_TOT = NUM_CH * CH_EVT_W;

    reg_dec_t            dec;
    logic [CH_TOT-1:0]   ch_stat_flat, ch_en_flat;
    logic [NUM_CH-1:0]   ch_pend;
    logic [CTL_W-1:0]    ctl_stat, ctl_en;
    logic                ctl_pend;
    logic [DATA_W-1:0]   mask_q, src;

    assign dec = decode_addr(reg_addr_i, NUM_CH);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = reg_we_i && (int'(dec.ch) == g);
        irq_w1c_bank #(.W(CH_EVT_W), .VALID({CH_EVT_W{1'b1}})) u_bank (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .evt_i    (ch_evt_i[g*CH_EVT_W +: CH_EVT_W]),
            .clr_we_i (hit && dec.sel == SEL_CH_CLR),
            .en_we_i  (hit && dec.sel == SEL_CH_EN),
            .wdata_i  (reg_wdata_i[CH_EVT_W-1:0]),
            .stat_o   (ch_stat_flat[g*CH_EVT_W +: CH_EVT_W]),
            .en_o     (ch_en_flat[g*CH_EVT_W +: CH_EVT_W]),
            .pend_o   (ch_pend[g])
        );
    end

    irq_w1c_bank #(.W(CTL_W), .VALID(CTL_VALID)) u_ctl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .evt_i    (ctl_evt_i),
        .clr_we_i (reg_we_i && dec.sel == SEL_CTL_CLR),
        .en_we_i  (reg_we_i && dec.sel == SEL_CTL_EN),
        .wdata_i  (reg_wdata_i[CTL_W-1:0]),
        .stat_o   (ctl_stat),
        .en_o     (ctl_en),
        .pend_o   (ctl_pend)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i)                               mask_q <= '0;
        else if (reg_we_i && dec.sel == SEL_MASK) mask_q <= reg_wdata_i;
    end

    irq_src_gate #(.NUM_CH(NUM_CH)) u_gate (
        .ch_pend_i  (ch_pend),
        .ctl_pend_i (ctl_pend),
        .mask_i     (mask_q),
        .src_o      (src),
        .irq_o      (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (dec.sel)
            SEL_CTL_STAT: reg_rdata_o[CTL_W-1:0] = ctl_stat;
            SEL_CTL_EN:   reg_rdata_o[CTL_W-1:0] = ctl_en;
            SEL_SRC:      reg_rdata_o = src;
            SEL_MASK:     reg_rdata_o = mask_q;
            SEL_CH_STAT, SEL_CH_EN: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (int'(dec.ch) == c) begin
                        reg_rdata_o[CH_EVT_W-1:0] = (dec.sel == SEL_CH_STAT)
                            ? ch_stat_flat[c*CH_EVT_W +: CH_EVT_W]
                            : ch_en_flat[c*CH_EVT_W +: CH_EVT_W];
                    end
                end
            end
            default:      reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk
    import irq_aggr_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int CH_EVT_W = 6
) (
    input logic                       clk_i,
    input logic                       rst_i,
    input logic                       we_i,
    input logic [NUM_CH*CH_EVT_W-1:0] ch_evt_i,
    input logic [CTL_W-1:0]           ctl_evt_i,
    input logic [NUM_CH*CH_EVT_W-1:0] ch_stat_i,
    input logic [CTL_W-1:0]           ctl_stat_i,
    input logic [DATA_W-1:0]          mask_i,
    input logic                       irq_i
);
    p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!irq_i && mask_i == '0));

    p_evt_sets_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((ch_stat_i & $past(ch_evt_i)) == $past(ch_evt_i)));

    p_stat_holds_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!we_i && ch_evt_i == '0) |=> $stable(ch_stat_i));

    p_ctl_evt_wins_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((ctl_stat_i[CTL_W-1:1] & $past(ctl_evt_i[CTL_W-1:1]))
                  == $past(ctl_evt_i[CTL_W-1:1])));

    p_no_mask_no_irq_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (mask_i == '0) |-> !irq_i);

    p_irq_level_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_i && !we_i) |=> irq_i);
endmodule

bind irq_aggr_top irq_aggr_chk #(.NUM_CH(NUM_CH), .CH_EVT_W(CH_EVT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .we_i       (reg_we_i),
    .ch_evt_i   (ch_evt_i),
    .ctl_evt_i  (ctl_evt_i),
    .ch_stat_i  (ch_stat_flat),
    .ctl_stat_i (ctl_stat),
    .mask_i     (mask_q),
    .irq_i      (irq_o)
);

// File: tb/test_irq_aggr_top.sv
module test_irq_aggr_top;
    localparam int NCH = 5;
    localparam int EW  = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              we = 1'b0;
    logic [7:0]        addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NCH*EW-1:0] ch_evt = '0;
    logic [4:0]        ctl_evt = '0;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    irq_aggr_top #(.NUM_CH(NCH), .CH_EVT_W(EW)) i_irq_aggr_top (
        .clk_i(clk), .rst_i(rst), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ch_evt_i(ch_evt),
        .ctl_evt_i(ctl_evt), .irq_o(irq)
    );

    function automatic logic [7:0] ch_adr(int c, int sub);
        return 8'(8'h10 + 4*c + sub);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic pulse_ch(int c, logic [EW-1:0] bits);
        @(negedge clk);
        ch_evt[c*EW +: EW] = bits;
        @(negedge clk);
        ch_evt = '0;
    endtask

    task automatic t_reset;
        rd_chk("R1 ctl status", 8'h00, 0);
        rd_chk("R1 ctl enable", 8'h02, 0);
        rd_chk("R1 source", 8'h03, 0);
        rd_chk("R1 mask", 8'h04, 0);
        rd_chk("R1 ch0 enable", ch_adr(0, 2), 0);
        rd_chk("R1 ch4 status", ch_adr(4, 0), 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_channel;
        pulse_ch(2, 6'b100101);
        rd_chk("R2 ch2 status set", ch_adr(2, 0), 32'h25);
        rd_chk("R4 not enabled, no source", 8'h03, 0);
        wr(ch_adr(2, 2), 32'hFFFF_FFFF);
        rd_chk("R9 enable keeps implemented bits", ch_adr(2, 2), 32'h3F);
        rd_chk("R9 clear reads zero", ch_adr(2, 1), 0);
        wr(ch_adr(2, 2), 32'h04);
        rd_chk("R4 source bit 2", 8'h03, 32'h4);
        chk("R7 irq low while masked", 32'(irq), 0);
        wr(8'h04, 32'h4);
        chk("R7 irq high when unmasked", 32'(irq), 1);
        wr(ch_adr(2, 1), 32'h20);
        rd_chk("R2 clear only written bits", ch_adr(2, 0), 32'h05);
        chk("R7 irq stays while pending", 32'(irq), 1);
        wr(ch_adr(2, 1), 32'h04);
        rd_chk("R2 clear enabled bit", ch_adr(2, 0), 32'h01);
        rd_chk("R4 source drops", 8'h03, 0);
        chk("R7 irq drops", 32'(irq), 0);
        wr(ch_adr(2, 1), 32'h3F);
        wr(ch_adr(2, 2), 32'h0);
    endtask

    task automatic t_two_channels;
        wr(ch_adr(0, 2), 32'h01);
        wr(ch_adr(3, 2), 32'h02);
        wr(8'h04, 32'h9);
        pulse_ch(0, 6'h01);
        pulse_ch(3, 6'h02);
        rd_chk("R4 two sources", 8'h03, 32'h9);
        wr(ch_adr(0, 1), 32'h01);
        chk("R7 irq held by other channel", 32'(irq), 1);
        wr(ch_adr(3, 1), 32'h02);
        chk("R7 irq clears with last source", 32'(irq), 0);
    endtask

    task automatic t_collide;
        pulse_ch(1, 6'h08);
        @(negedge clk);
        ch_evt[1*EW +: EW] = 6'h08;
        we = 1'b1; addr = ch_adr(1, 1); wdata = 32'h08;
        ctl_evt = 5'b00100;
        @(negedge clk);
        we = 1'b0; wdata = '0; ch_evt = '0; ctl_evt = '0;
        rd_chk("R3 channel event beats clear", ch_adr(1, 0), 32'h08);
        @(negedge clk);
        we = 1'b1; addr = 8'h01; wdata = 32'h04; ctl_evt = 5'b00100;
        @(negedge clk);
        we = 1'b0; wdata = '0; ctl_evt = '0;
        rd_chk("R3 controller event beats clear", 8'h00, 32'h04);
        wr(ch_adr(1, 1), 32'h3F);
        wr(8'h01, 32'h1E);
        rd_chk("R3 cleared afterwards", ch_adr(1, 0), 0);
    endtask

    task automatic t_controller;
        @(negedge clk);
        ctl_evt = 5'b11111;
        @(negedge clk);
        ctl_evt = '0;
        rd_chk("R5 controller status, bit0 reserved", 8'h00, 32'h1E);
        rd_chk("R6 no summary while disabled", 8'h03, 0);
        wr(8'h02, 32'hFFFF_FFFF);
        rd_chk("R5 controller enable width", 8'h02, 32'h1E);
        wr(8'h02, 32'h1 << 2);
        rd_chk("R6 controller summary", 8'h03, 32'h8000_0000);
        wr(8'h04, 32'h8000_0000);
        chk("R7 irq from controller", 32'(irq), 1);
        wr(8'h01, 32'h1A);
        rd_chk("R5 controller w1c partial", 8'h00, 32'h04);
        wr(8'h01, 32'h04);
        rd_chk("R5 controller cleared", 8'h00, 0);
        chk("R6 irq drops", 32'(irq), 0);
    endtask

    task automatic t_src_readonly;
        wr(8'h04, 32'h0000_0012);
        wr(8'h03, 32'hFFFF_FFFF);
        rd_chk("R8 source unchanged", 8'h03, 0);
        rd_chk("R8 mask unchanged", 8'h04, 32'h12);
        rd_chk("R8 controller enable unchanged", 8'h02, 32'h04);
        chk("R8 irq unchanged", 32'(irq), 0);
    endtask

    task automatic t_unimpl;
        wr(ch_adr(6, 2), 32'h3F);
        rd_chk("R9 absent channel enable", ch_adr(6, 2), 0);
        rd_chk("R9 unmapped gap", 8'h05, 0);
        wr(8'h05, 32'hFFFF_FFFF);
        rd_chk("R9 gap write ignored, mask", 8'h04, 32'h12);
        for (int c = 0; c < NCH; c++) wr(ch_adr(c, 2), 32'h3F);
        wr(8'h04, 32'hFFFF_FFFF);
        @(negedge clk);
        ch_evt = '1;
        @(negedge clk);
        ch_evt = '0;
        rd_chk("R4 unimplemented source bits zero", 8'h03, 32'h1F);
        chk("R7 irq all pending", 32'(irq), 1);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_channel();
        t_two_channels();
        t_collide();
        t_controller();
        t_src_readonly();
        t_unimpl();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule